// File: doc/BRIEF.md
# Oscillator-Stop and Low-Supply Status Flags

This block keeps two sticky status flags for a timekeeping device: one that records that the crystal oscillator stopped, and one that records that the supply voltage fell below a selectable threshold. Both detectors are analog circuits outside the block. Here they appear as two asynchronous digital inputs. Each input passes through a two-flop synchronizer before the flag logic samples it.

A halt event does more than set the halt flag. It also forces the supply flag to zero and clears the comparator threshold select. It also emits a clear pulse that the surrounding configuration registers use to zero their trim, alarm-enable, hour-mode, test, periodic-interrupt, scratch and alarm/interrupt flag bits. Power-on reset sets the halt flag, so software can tell that a cold start happened. After reset, the comparator input is ignored for a programmable settling window. Software reads the flags directly and clears each one by writing zero to its bit.

Top module: `osc_supply_flags`

## Requirements
- R1: While reset is high and after it is released, the halt flag reads 1, the supply flag reads 0, the threshold select reads 0 and the clear pulse reads 0.
- R2: A high level on the halt-detect input sets the halt flag at the third rising clock edge after the input changes: two synchronizer edges, then the flag register.
- R3: A halt event forces the supply flag to 0 on the same edge that sets the halt flag. This holds even when the comparator input is also asserted.
- R4: The clear pulse output is high for exactly the cycles that follow a clock edge at which a synchronized halt event was present. It is therefore high in the same cycle that the halt flag is set.
- R5: The threshold select output holds the last value written through the threshold write port, where 0 selects 2.1 V and 1 selects 1.6 V. A halt event forces it to 0, and the halt event wins over a write in the same cycle.
- R6: For INIT_CYCLES clock cycles after reset is released, the comparator input has no effect on the supply flag.
- R7: Once the settling window has ended, a high comparator input sets the supply flag at the third rising edge after the input changes.
- R8: Both flags are sticky. A host write with wr_data bit 1 = 0 clears the halt flag, and a write with wr_data bit 0 = 0 clears the supply flag. A 1 in either bit leaves that flag unchanged.
- R9: When a set condition and a host clear of the same flag occur in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| halt_det_a | input | 1 | Oscillator-stop detector output (asynchronous) |
| lowv_a | input | 1 | Supply comparator output, high means below threshold (asynchronous) |
| wr_en | input | 1 | Host write strobe for the flag register |
| wr_data | input | 2 | Host write data: bit 1 halt flag, bit 0 supply flag; 0 clears |
| thr_wr_en | input | 1 | Host write strobe for the threshold select |
| thr_wr_val | input | 1 | Threshold value to write (0 = 2.1 V, 1 = 1.6 V) |
| halt_flag | output | 1 | Oscillator-stop flag |
| volt_flag | output | 1 | Low-supply flag |
| thr_sel | output | 1 | Threshold select to the analog comparator |
| cfg_clr | output | 1 | Clear pulse to the configuration registers |

## Verification
The bench holds the comparator high through reset and checks the supply flag both inside and beyond the settling window. A design that does not gate the comparator would set the flag early, and one with the wrong window length would miss the late check. It raises a halt while the supply flag and the threshold select are both 1, to catch a design that leaves either one standing. The same scenario measures the width of the clear pulse, which exposes a design that stretches it. It issues clears together with a live set on each flag, which separates a design where the set wins from one where the clear wins. It also writes ones, to catch a design that decodes the write polarity backwards.

// File: rtl/osf_pkg.sv
package osf_pkg;

    localparam int WR_HALT_BIT = 1;
    localparam int WR_VOLT_BIT = 0;
    localparam int WR_W        = 2;

    typedef struct packed {
        logic halt;
        logic volt;
    } flag_pair_t;

    typedef struct packed {
        logic halt_evt;
        logic volt_evt;
    } event_t;

    // Halt flag: a set outranks a host clear.
    function automatic logic next_halt(input logic cur, input logic evt,
                                       input logic clr_req);
        if (evt)          return 1'b1;
        else if (clr_req) return 1'b0;
        else              return cur;
    endfunction

    // Supply flag: a halt forces zero, then the comparator set, then the host clear.
    function automatic logic next_volt(input logic cur, input logic halt_evt,
                                       input logic volt_evt, input logic clr_req);
        if (halt_evt)      return 1'b0;
        else if (volt_evt) return 1'b1;
        else if (clr_req)  return 1'b0;
        else               return cur;
    endfunction

endpackage

// File: rtl/osf_sync.sv
module osf_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/osf_init_timer.sv
module osf_init_timer #(
    parameter int INIT_CYCLES = 32768
) (
    input  logic clk,
    input  logic rst,
    output logic done
);
    localparam int CW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(INIT_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LIMIT);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);
endmodule

// File: rtl/osf_flag_core.sv
module osf_flag_core
    import osf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            halt_s,
    input  logic            lowv_s,
    input  logic            init_done,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    input  logic            thr_wr_en,
    input  logic            thr_wr_val,
    output flag_pair_t      flags,
    output logic            thr_sel,
    output logic            cfg_clr
);
    event_t     evt;
    flag_pair_t flags_q, flags_n;
    logic       thr_q, thr_n, clr_q;
    logic       halt_clr_req, volt_clr_req;

    always_comb begin
        evt.halt_evt  = halt_s;
        evt.volt_evt  = lowv_s && init_done;
        halt_clr_req  = wr_en && !wr_data[WR_HALT_BIT];
        volt_clr_req  = wr_en && !wr_data[WR_VOLT_BIT];
        flags_n.halt  = next_halt(flags_q.halt, evt.halt_evt, halt_clr_req);
        flags_n.volt  = next_volt(flags_q.volt, evt.halt_evt, evt.volt_evt, volt_clr_req);
        thr_n         = evt.halt_evt ? 1'b0 : (thr_wr_en ? thr_wr_val : thr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '{halt: 1'b1, volt: 1'b0};
            thr_q   <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            flags_q <= flags_n;
            thr_q   <= thr_n;
            clr_q   <= evt.halt_evt;
        end
    end

    assign flags   = flags_q;
    assign thr_sel = thr_q;
    assign cfg_clr = clr_q;

    p_halt_set_r2: assert property (@(posedge clk) disable iff (rst)
        halt_s |=> flags_q.halt);
    p_volt_zero_on_halt_r3: assert property (@(posedge clk) disable iff (rst)
        halt_s |=> !flags_q.volt);
    p_clr_with_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.halt) |-> clr_q);
    p_thr_zero_on_halt_r5: assert property (@(posedge clk) disable iff (rst)
        halt_s |=> !thr_q);
    p_init_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (!init_done && !flags_q.volt) |=> !flags_q.volt);
    p_sticky_halt_r8: assert property (@(posedge clk) disable iff (rst)
        (flags_q.halt && !(wr_en && !wr_data[WR_HALT_BIT])) |=> flags_q.halt);
    p_sticky_volt_r8: assert property (@(posedge clk) disable iff (rst)
        (flags_q.volt && !halt_s && !(wr_en && !wr_data[WR_VOLT_BIT])) |=> flags_q.volt);
endmodule

// File: rtl/osc_supply_flags.sv
module osc_supply_flags
    import osf_pkg::*;
#(
    parameter int INIT_CYCLES = 32768,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            halt_det_a,
    input  logic            lowv_a,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    input  logic            thr_wr_en,
    input  logic            thr_wr_val,
    output logic            halt_flag,
    output logic            volt_flag,
    output logic            thr_sel,
    output logic            cfg_clr
);
    logic [1:0] raw_in, sync_out;
    logic       init_done;
    flag_pair_t flags;

    assign raw_in = {halt_det_a, lowv_a};

    osf_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .din (raw_in), .dout (sync_out)
    );

    osf_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
        .clk (clk), .rst (rst), .done (init_done)
    );

    osf_flag_core u_core (
        .clk        (clk),
        .rst        (rst),
        .halt_s     (sync_out[1]),
        .lowv_s     (sync_out[0]),
        .init_done  (init_done),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .thr_wr_en  (thr_wr_en),
        .thr_wr_val (thr_wr_val),
        .flags      (flags),
        .thr_sel    (thr_sel),
        .cfg_clr    (cfg_clr)
    );

    assign halt_flag = flags.halt;
    assign volt_flag = flags.volt;

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (halt_flag && !volt_flag && !thr_sel && !cfg_clr));
endmodule

// File: tb/osc_supply_flags_bench.sv
module osc_supply_flags_bench;
    localparam int CLK_PERIOD = 10;
    localparam int INIT_N     = 40;

    logic       clk = 1'b0;
    logic       rst;
    logic       halt_det_a, lowv_a, wr_en, thr_wr_en, thr_wr_val;
    logic [1:0] wr_data;
    logic       halt_flag, volt_flag, thr_sel, cfg_clr;
    int         total = 0;
    int         bad   = 0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_supply_flags #(.INIT_CYCLES(INIT_N)) u_osc_supply_flags (
        .clk (clk), .rst (rst), .halt_det_a (halt_det_a), .lowv_a (lowv_a),
        .wr_en (wr_en), .wr_data (wr_data), .thr_wr_en (thr_wr_en),
        .thr_wr_val (thr_wr_val), .halt_flag (halt_flag), .volt_flag (volt_flag),
        .thr_sel (thr_sel), .cfg_clr (cfg_clr)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] d);
        wr_en = 1'b1; wr_data = d;
        cycles(1);
        wr_en = 1'b0; wr_data = 2'b11;
    endtask

    // R1, R6, R7: reset state, then comparator gated by settling window
    task automatic t_reset_and_init();
        rst = 1'b1; lowv_a = 1'b1;
        cycles(3);
        check("R1 halt in reset", halt_flag, 1'b1);
        check("R1 volt in reset", volt_flag, 1'b0);
        check("R1 thr in reset", thr_sel, 1'b0);
        check("R1 clr in reset", cfg_clr, 1'b0);
        rst = 1'b0;
        cycles(1);
        check("R1 halt after release", halt_flag, 1'b1);
        check("R1 clr after release", cfg_clr, 1'b0);
        cycles(INIT_N - 6);
        check("R6 volt ignored in window", volt_flag, 1'b0);
        cycles(8);
        check("R7 volt set after window", volt_flag, 1'b1);
        lowv_a = 1'b0;
        cycles(3);
    endtask

    // R8: write-zero clears, write-one leaves unchanged
    task automatic t_clear_writes();
        host_write(2'b11);
        check("R8 write ones keeps halt", halt_flag, 1'b1);
        check("R8 write ones keeps volt", volt_flag, 1'b1);
        host_write(2'b01);
        check("R8 clear halt", halt_flag, 1'b0);
        check("R8 volt untouched", volt_flag, 1'b1);
        host_write(2'b10);
        check("R8 clear volt", volt_flag, 1'b0);
        check("R8 halt stays clear", halt_flag, 1'b0);
        host_write(2'b11);
        check("R8 write ones no set", halt_flag | volt_flag, 1'b0);
    endtask

    // R7, R5: comparator sets supply flag; threshold write
    task automatic t_lowv_and_thr();
        lowv_a = 1'b1;
        cycles(2);
        check("R7 not yet set", volt_flag, 1'b0);
        cycles(1);
        check("R7 set third edge", volt_flag, 1'b1);
        lowv_a = 1'b0;
        thr_wr_en = 1'b1; thr_wr_val = 1'b1;
        cycles(1);
        thr_wr_en = 1'b0; thr_wr_val = 1'b0;
        check("R5 thr written", thr_sel, 1'b1);
        cycles(3);
        check("R5 thr held", thr_sel, 1'b1);
    endtask

    // R2, R3, R4, R5: halt pulse side effects
    task automatic t_halt_event();
        halt_det_a = 1'b1; lowv_a = 1'b1;
        cycles(1);
        halt_det_a = 1'b0;
        cycles(1);
        check("R2 halt not before third edge", halt_flag, 1'b0);
        check("R4 clr not early", cfg_clr, 1'b0);
        cycles(1);
        check("R2 halt set", halt_flag, 1'b1);
        check("R3 volt forced zero", volt_flag, 1'b0);
        check("R4 clr high", cfg_clr, 1'b1);
        check("R5 thr cleared", thr_sel, 1'b0);
        cycles(1);
        check("R4 clr one cycle", cfg_clr, 1'b0);
        lowv_a = 1'b0;
        cycles(3);
        host_write(2'b00);
    endtask

    // R9, R5: set wins over clear
    task automatic t_set_vs_clear();
        halt_det_a = 1'b1;
        cycles(3);
        check("R9 halt set", halt_flag, 1'b1);
        thr_wr_en = 1'b1; thr_wr_val = 1'b1;
        host_write(2'b01);
        thr_wr_en = 1'b0; thr_wr_val = 1'b0;
        check("R9 halt set beats clear", halt_flag, 1'b1);
        check("R5 halt beats thr write", thr_sel, 1'b0);
        halt_det_a = 1'b0;
        cycles(3);
        host_write(2'b01);
        check("R8 halt cleared after release", halt_flag, 1'b0);
        lowv_a = 1'b1;
        cycles(3);
        host_write(2'b10);
        check("R9 volt set beats clear", volt_flag, 1'b1);
        lowv_a = 1'b0;
        cycles(3);
        host_write(2'b10);
        check("R8 volt cleared after release", volt_flag, 1'b0);
    endtask

    initial begin
        halt_det_a = 1'b0; lowv_a = 1'b0; wr_en = 1'b0; wr_data = 2'b11;
        thr_wr_en = 1'b0; thr_wr_val = 1'b0; rst = 1'b1;
        @(negedge clk);
        t_reset_and_init();
        t_clear_writes();
        t_lowv_and_thr();
        t_halt_event();
        t_set_vs_clear();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule